// File: doc/BRIEF.md
# Shared Serial Bus Sender with Echo Verification

This block sends fixed-length messages onto a multi-drop, half-duplex serial bus that a radio shares with its accessories. Every party on the bus watches a common busy line. When a message is waiting, the block waits for that line to be quiet. It then raises its own busy drive for one claim cycle. If no other party claimed in that same cycle, it hands the message one byte at a time to a UART transmitter.

Because the bus is shared and reads back what is on the wire, every byte that is sent comes back on the receive side. The block compares each returned byte with the byte it sent. It offers the next byte only after a good echo. A wrong echo, or no echo within two byte times, aborts the whole message. The block then drops its busy drive, waits a programmable backoff and sends the message again from its first byte. A run of consecutive failed attempts makes the block pulse a bus-wide reset line instead. After the pulse it clears its failure count, backs off and tries again.

The requester presents the message on a flat data vector and holds a request level until the one-cycle done pulse. The line transceivers sit outside this block.

Top module: `shared_bus_sender`

## Requirements
- R1: With msg_req high, the block claims the bus (busy_out rises) only after a cycle in which busy_in was sampled low. While busy_in stays high, busy_out and tx_valid stay low.
- R2: busy_out (active high) is high only during the claim cycle, while a byte is offered and while an echo is awaited. tx_valid is never high without busy_out.
- R3: A message is MSG_BYTES bytes (default 5). Byte 0, msg_data[7:0], is offered first, and byte i is msg_data[8*i+7:8*i]. While tx_valid is high and tx_ready is low, tx_valid and tx_data hold.
- R4: After a byte is accepted (tx_valid and tx_ready high at a clock edge), tx_valid drops. The next byte is offered only in the cycle after an rx_valid whose rx_data equals the byte sent.
- R5: After a good echo of the last byte, msg_done is high for exactly one cycle. In that cycle busy_out is low.
- R6: An echo that differs from the sent byte aborts the message. In the next cycle busy_out and tx_valid are low. With busy_in low and msg_req held, busy_out stays low for backoff_len+2 cycles, and the retry offers byte 0 again.
- R7: If no rx_valid arrives within ECHO_TIMEOUT = 2*BYTE_CYCLES cycles after a byte is accepted, the attempt fails exactly as for a wrong echo.
- R8: The failure that makes ERR_LIMIT consecutive failures drives bus_reset_out high for RESET_CYCLES cycles, with busy_out and tx_valid low. The block then backs off for backoff_len+1 cycles and retries, so busy_out stays low for RESET_CYCLES+backoff_len+2 cycles.
- R9: A successful message clears the failure count. ERR_LIMIT-1 failures, then a success, then ERR_LIMIT-1 more failures produce no bus reset.
- R10: If busy_in is high during the claim cycle, the block drops busy_out in the next cycle, sends nothing and backs off. Such a collision does not count as a failure.
- R11: rx_valid outside the echo wait has no effect on any output.
- R12: During reset, busy_out, tx_valid, bus_reset_out and msg_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_req | input | 1 | A message is waiting; held until msg_done |
| msg_data | input | MSG_BYTES*8 | Message bytes, byte 0 in the low bits |
| msg_done | output | 1 | One-cycle pulse when a message went through cleanly |
| backoff_len | input | BACKOFF_W | Backoff length after a failure or collision |
| busy_in | input | 1 | Busy level asserted by the other bus parties |
| busy_out | output | 1 | This block's busy drive |
| bus_reset_out | output | 1 | Bus-wide reset pulse after repeated failures |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_data | output | 8 | Offered byte |
| tx_ready | input | 1 | UART transmitter takes the byte |
| rx_valid | input | 1 | UART receiver has a byte |
| rx_data | input | 8 | Received (echoed) byte |

## Verification
The checker watches every cycle for several rules. A claim must follow a quiet busy sample. Bytes are offered only under the block's own busy drive and hold steady while stalled. tx_valid drops after a handshake. The bus reset never overlaps busy or a byte offer. msg_done is a single cycle with busy released. A same-cycle collision gives way at once.

Some behaviours only the bench's scenarios can show. These are the order and values of the bytes, and the restart from byte 0 after a bad or missing echo. They also include the exact timeout and backoff lengths, the count of consecutive failures that leads to escalation, and the clearing of that count by a success. The last is that stray receive bytes and collisions leave the outputs and the failure count alone.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef logic [7:0] sbs_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLAIM   = 3'd1,
        ST_SEND    = 3'd2,
        ST_ECHO    = 3'd3,
        ST_BACKOFF = 3'd4,
        ST_RESET   = 3'd5
    } sbs_state_e;

    typedef struct packed {
        logic pass;
        logic fail;
    } sbs_verdict_t;

    function automatic int sbs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Outcome of one echo-wait cycle: a matching byte passes, a differing
    // byte or an expired wait fails, otherwise keep waiting.
    function automatic sbs_verdict_t sbs_judge(input logic got, input sbs_byte_t rx,
                                               input sbs_byte_t tx, input logic expired);
        sbs_verdict_t v;
        v.pass = got && (rx == tx);
        v.fail = (got && (rx != tx)) || (!got && expired);
        return v;
    endfunction

endpackage

// File: rtl/sbs_timer.sv
module sbs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sbs_fail_tracker.sv
module sbs_fail_tracker #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fail,
    output logic escalate_next
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (fail)
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end

    // The next failure is the one that reaches the limit.
    assign escalate_next = (cnt == TOP);
endmodule

// File: rtl/sbs_byte_mux.sv
module sbs_byte_mux #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N*8-1:0]        flat,
    input  logic [IW-1:0]         sel,
    output sbs_pkg::sbs_byte_t    q
);
    sbs_pkg::sbs_byte_t lane [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane[g] = flat[g*8 +: 8];
    end

    always_comb begin
        q = '0;
        for (int i = 0; i < N; i++)
            if (sel == IW'(i))
                q = lane[i];
    end
endmodule

// File: rtl/shared_bus_sender.sv
module shared_bus_sender
    import sbs_pkg::*;
#(
    parameter int MSG_BYTES    = 5,
    parameter int BYTE_CYCLES  = 16,
    parameter int ERR_LIMIT    = 3,
    parameter int RESET_CYCLES = 8,
    parameter int BACKOFF_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   msg_req,
    input  logic [MSG_BYTES*8-1:0] msg_data,
    output logic                   msg_done,
    input  logic [BACKOFF_W-1:0]   backoff_len,
    input  logic                   busy_in,
    output logic                   busy_out,
    output logic                   bus_reset_out,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    input  logic                   tx_ready,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data
);
    localparam int MSG_W        = MSG_BYTES * 8;
    localparam int IDX_W        = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
    localparam int ECHO_TIMEOUT = 2 * BYTE_CYCLES;
    localparam int ECHO_W       = $clog2(ECHO_TIMEOUT + 1);
    localparam int RST_W        = $clog2(RESET_CYCLES + 1);
    localparam int TMR_W        = sbs_max(sbs_max(ECHO_W, RST_W), BACKOFF_W);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(MSG_BYTES - 1);
    localparam logic [TMR_W-1:0] ECHO_LOAD = TMR_W'(ECHO_TIMEOUT - 1);
    localparam logic [TMR_W-1:0] RST_LOAD  = TMR_W'(RESET_CYCLES - 1);

    sbs_state_e        st_q, st_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic [MSG_W-1:0]  msg_q, msg_n;
    logic              done_q, done_n;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              trk_fail, trk_clear, escalate_next;
    sbs_byte_t         cur_byte;
    sbs_verdict_t      verdict;
    logic [TMR_W-1:0]  bo_load;

    assign bo_load = TMR_W'(backoff_len);

    sbs_byte_mux #(.N(MSG_BYTES), .IW(IDX_W)) u_mux (
        .flat (msg_q),
        .sel  (idx_q),
        .q    (cur_byte)
    );

    sbs_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sbs_fail_tracker #(.LIMIT(ERR_LIMIT)) u_track (
        .clk           (clk),
        .rst           (rst),
        .clear         (trk_clear),
        .fail          (trk_fail),
        .escalate_next (escalate_next)
    );

    assign verdict = sbs_judge(rx_valid, rx_data, cur_byte, tmr_expired);

    always_comb begin
        st_n      = st_q;
        idx_n     = idx_q;
        msg_n     = msg_q;
        done_n    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        trk_fail  = 1'b0;
        trk_clear = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (msg_req && !busy_in) begin
                    st_n  = ST_CLAIM;
                    msg_n = msg_data;
                end
            end
            ST_CLAIM: begin
                if (busy_in) begin
                    st_n     = ST_BACKOFF;
                    tmr_load = 1'b1;
                    tmr_val  = bo_load;
                end else begin
                    st_n  = ST_SEND;
                    idx_n = '0;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    st_n     = ST_ECHO;
                    tmr_load = 1'b1;
                    tmr_val  = ECHO_LOAD;
                end
            end
            ST_ECHO: begin
                if (verdict.pass) begin
                    if (idx_q == LAST_IDX) begin
                        st_n      = ST_IDLE;
                        done_n    = 1'b1;
                        trk_clear = 1'b1;
                    end else begin
                        st_n  = ST_SEND;
                        idx_n = idx_q + 1'b1;
                    end
                end else if (verdict.fail) begin
                    trk_fail = 1'b1;
                    tmr_load = 1'b1;
                    if (escalate_next) begin
                        st_n    = ST_RESET;
                        tmr_val = RST_LOAD;
                    end else begin
                        st_n    = ST_BACKOFF;
                        tmr_val = bo_load;
                    end
                end
            end
            ST_RESET: begin
                if (tmr_expired) begin
                    st_n     = ST_BACKOFF;
                    tmr_load = 1'b1;
                    tmr_val  = bo_load;
                end
            end
            ST_BACKOFF: begin
                if (tmr_expired)
                    st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            msg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            idx_q  <= idx_n;
            msg_q  <= msg_n;
            done_q <= done_n;
        end
    end

    assign busy_out      = (st_q == ST_CLAIM) || (st_q == ST_SEND) || (st_q == ST_ECHO);
    assign tx_valid      = (st_q == ST_SEND);
    assign tx_data       = cur_byte;
    assign bus_reset_out = (st_q == ST_RESET);
    assign msg_done      = done_q;
endmodule

// File: rtl/shared_bus_sender_chk.sv
module shared_bus_sender_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_in,
    input logic       busy_out,
    input logic       bus_reset_out,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       msg_done
);
    AST_CLAIM_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_out) |-> $past(!busy_in));                                     // R1

    AST_TX_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy_out);                                                   // R2

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));              // R3

    AST_TX_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_valid);                                    // R4

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        msg_done |-> (!busy_out && !bus_reset_out));                              // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        msg_done |=> !msg_done);                                                  // R5

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_reset_out |-> (!busy_out && !tx_valid));                              // R8

    AST_COLLIDE_YIELD: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy_out) && busy_in) |=> (!busy_out && !tx_valid));               // R10
endmodule

bind shared_bus_sender shared_bus_sender_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy_in       (busy_in),
    .busy_out      (busy_out),
    .bus_reset_out (bus_reset_out),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .msg_done      (msg_done)
);

// File: tb/shared_bus_sender_bench.sv
module shared_bus_sender_bench;
    localparam int MB   = 5;
    localparam int BC   = 4;
    localparam int TOUT = 2 * BC;
    localparam int LIM  = 3;
    localparam int RCY  = 3;
    localparam int BW   = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          msg_req;
    logic [MB*8-1:0] msg_data;
    logic          msg_done;
    logic [BW-1:0] backoff_len;
    logic          busy_in;
    logic          busy_out;
    logic          bus_reset_out;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready;
    logic          rx_valid;
    logic [7:0]    rx_data;

    int n_checks = 0;
    int n_fail   = 0;
    int rst_cycles = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    shared_bus_sender #(
        .MSG_BYTES(MB), .BYTE_CYCLES(BC), .ERR_LIMIT(LIM),
        .RESET_CYCLES(RCY), .BACKOFF_W(BW)
    ) u_shared_bus_sender (
        .clk(clk), .rst(rst), .msg_req(msg_req), .msg_data(msg_data),
        .msg_done(msg_done), .backoff_len(backoff_len), .busy_in(busy_in),
        .busy_out(busy_out), .bus_reset_out(bus_reset_out), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always @(negedge clk) if (!rst && bus_reset_out) rst_cycles++;

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [MB*8-1:0] m, input int i);
        return m[8*i +: 8];
    endfunction

    // kind: 0 clean, 1 wrong echo at fbyte, 2 no echo at fbyte; noise: stray rx while offering byte 0
    task automatic run_attempt(input logic [MB*8-1:0] m, input int fbyte, input int kind,
                               input bit noise, output bit ok);
        int guard = 0;
        ok = 0;
        while (!tx_valid && guard < 500) begin @(negedge clk); guard++; end
        if (!tx_valid) begin
            check(0, "R1", "no byte offered", 0, 1);
            return;
        end
        for (int i = 0; i < MB; i++) begin
            check(tx_valid === 1'b1 && tx_data === exp_byte(m, i), "R3", "offered byte",
                  {tx_valid, tx_data}, {1'b1, exp_byte(m, i)});
            if (noise && i == 0) begin
                rx_valid = 1'b1; rx_data = exp_byte(m, 0);
                @(negedge clk);
                rx_valid = 1'b0;
                check(tx_valid === 1'b1 && tx_data === exp_byte(m, 0), "R11",
                      "stray rx while offering", tx_data, exp_byte(m, 0));
            end
            for (int s = 0, n = $urandom_range(0, 2); s < n; s++) begin
                @(negedge clk);
                check(tx_valid === 1'b1 && tx_data === exp_byte(m, i), "R3",
                      "hold while stalled", tx_data, exp_byte(m, i));
            end
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            check(tx_valid === 1'b0, "R4", "offer drops after take", tx_valid, 0);
            if (i == fbyte && kind == 2) begin
                for (int w = 0; w < TOUT - 1; w++) @(negedge clk);
                check(busy_out === 1'b1 && tx_valid === 1'b0, "R7", "still waiting at last echo cycle",
                      busy_out, 1);
                @(negedge clk);
                check(busy_out === 1'b0 && tx_valid === 1'b0, "R7", "timeout aborts", busy_out, 0);
                return;
            end
            for (int d = 0, n = $urandom_range(0, TOUT - 2); d < n; d++) begin
                @(negedge clk);
                check(tx_valid === 1'b0, "R4", "no next byte before echo", tx_valid, 0);
            end
            rx_valid = 1'b1;
            rx_data  = (i == fbyte && kind == 1) ? exp_byte(m, i) ^ (8'h01 << $urandom_range(0, 7))
                                                 : exp_byte(m, i);
            @(negedge clk);
            rx_valid = 1'b0;
            if (i == fbyte && kind == 1) begin
                check(busy_out === 1'b0 && tx_valid === 1'b0, "R6", "wrong echo aborts",
                      {busy_out, tx_valid}, 0);
                return;
            end
        end
        check(msg_done === 1'b1 && busy_out === 1'b0, "R5", "done with busy released",
              {msg_done, busy_out}, 2'b10);
        ok = 1;
    endtask

    task automatic finish_msg();
        msg_req = 1'b0;
        @(negedge clk);
        check(msg_done === 1'b0, "R5", "done lasts one cycle", msg_done, 0);
    endtask

    task automatic measure_gap(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (busy_out || n > 3000) break;
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        bit ok;
        int gap;
        int rc0;
        logic [MB*8-1:0] m;
        void'($urandom(32'd4711));
        rst = 1'b1; msg_req = 0; msg_data = '0; backoff_len = 2; busy_in = 0;
        tx_ready = 0; rx_valid = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        check(busy_out === 0 && tx_valid === 0 && bus_reset_out === 0 && msg_done === 0,
              "R12", "reset outputs", {busy_out, tx_valid, bus_reset_out, msg_done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R11: stray receive byte while idle
        rx_valid = 1; rx_data = 8'h5A;
        @(negedge clk);
        rx_valid = 0;
        @(negedge clk);
        check(busy_out === 0 && tx_valid === 0 && msg_done === 0 && bus_reset_out === 0,
              "R11", "idle rx ignored", {busy_out, tx_valid, msg_done}, 0);

        // R1: bus held busy by others
        m = 40'h44_33_22_11_A5;
        msg_data = m; busy_in = 1; msg_req = 1;
        begin
            bit quiet = 1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (busy_out !== 0 || tx_valid !== 0) quiet = 0;
            end
            check(quiet, "R1", "no claim while busy_in high", quiet, 1);
        end
        busy_in = 0;
        run_attempt(m, -1, 0, 1, ok);
        check(ok, "R2", "clean message completes", ok, 1);
        finish_msg();

        // R6: wrong echo at byte 2, then full resend
        m = 40'hDE_AD_BE_EF_01; msg_data = m; backoff_len = 3; msg_req = 1;
        run_attempt(m, 2, 1, 0, ok);
        check(!ok, "R6", "attempt fails", ok, 0);
        measure_gap(gap);
        check(gap == 3 + 2, "R6", "backoff gap", gap, 5);
        run_attempt(m, -1, 0, 0, ok);
        check(ok, "R6", "retry from byte 0 succeeds", ok, 1);
        finish_msg();

        // R7: silent echo on last byte
        m = 40'h10_20_30_40_50; msg_data = m; backoff_len = 0; msg_req = 1;
        run_attempt(m, MB - 1, 2, 0, ok);
        check(!ok, "R7", "timeout attempt fails", ok, 0);
        measure_gap(gap);
        check(gap == 2, "R7", "gap after timeout", gap, 2);
        run_attempt(m, -1, 0, 0, ok);
        check(ok, "R7", "retry succeeds", ok, 1);
        finish_msg();

        // R9: success clears the failure count
        rc0 = rst_cycles;
        backoff_len = 1;
        for (int round = 0; round < 2; round++) begin
            m = {$urandom, 8'(round)}; msg_data = m; msg_req = 1;
            for (int f = 0; f < LIM - 1; f++) begin
                run_attempt(m, f, 1, 0, ok);
                measure_gap(gap);
                check(gap == 1 + 2, "R9", "gap below limit", gap, 3);
            end
            run_attempt(m, -1, 0, 0, ok);
            check(ok, "R9", "success after failures", ok, 1);
            finish_msg();
        end
        check(rst_cycles == rc0, "R9", "no bus reset", rst_cycles - rc0, 0);

        // R8: limit of consecutive failures escalates
        m = 40'hCA_FE_F0_0D_77; msg_data = m; msg_req = 1; backoff_len = 2;
        rc0 = rst_cycles;
        for (int f = 0; f < LIM - 1; f++) begin
            run_attempt(m, 0, 1, 0, ok);
            measure_gap(gap);
        end
        run_attempt(m, 3, 1, 0, ok);
        check(bus_reset_out === 1'b1, "R8", "reset pulse starts", bus_reset_out, 1);
        measure_gap(gap);
        check(gap == RCY + 2 + 2, "R8", "reset plus backoff gap", gap, RCY + 4);
        check(rst_cycles - rc0 == RCY, "R8", "reset pulse length", rst_cycles - rc0, RCY);
        run_attempt(m, -1, 0, 0, ok);
        check(ok, "R8", "retry after reset succeeds", ok, 1);
        finish_msg();

        // R10: collisions yield and are not counted
        rc0 = rst_cycles;
        m = 40'h0F_1E_2D_3C_4B; msg_data = m; backoff_len = 1;
        for (int c = 0; c < LIM + 1; c++) begin
            int guard = 0;
            msg_req = 1; busy_in = 0;
            while (!busy_out && guard < 100) begin @(negedge clk); guard++; end
            check(busy_out === 1 && tx_valid === 0, "R10", "claim cycle seen", busy_out, 1);
            busy_in = 1;
            @(negedge clk);
            check(busy_out === 0 && tx_valid === 0, "R10", "yield on collision",
                  {busy_out, tx_valid}, 0);
            begin
                bit quiet = 1;
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    if (busy_out !== 0 || tx_valid !== 0) quiet = 0;
                end
                check(quiet, "R1", "wait while others busy", quiet, 1);
            end
        end
        busy_in = 0;
        run_attempt(m, -1, 0, 0, ok);
        check(ok, "R10", "send after collisions", ok, 1);
        finish_msg();
        check(rst_cycles == rc0, "R10", "collisions not counted", rst_cycles - rc0, 0);

        // Random phase
        rc0 = rst_cycles;
        for (int t = 0; t < 25; t++) begin
            int r = $urandom_range(0, 9);
            int kind = (r < 3) ? 1 : (r == 3) ? 2 : 0;
            int fb = $urandom_range(0, MB - 1);
            int bl = $urandom_range(0, 4);
            m = {8'($urandom), $urandom};
            msg_data = m; backoff_len = BW'(bl); msg_req = 1;
            run_attempt(m, (kind == 0) ? -1 : fb, kind, 0, ok);
            if (kind != 0) begin
                check(!ok, "R6", "random fault fails", ok, 0);
                measure_gap(gap);
                check(gap == bl + 2, "R6", "random backoff gap", gap, bl + 2);
                run_attempt(m, -1, 0, 0, ok);
            end
            check(ok, "R3", "random message delivered", ok, 1);
            finish_msg();
        end
        check(rst_cycles == rc0, "R9", "isolated faults never escalate", rst_cycles - rc0, 0);

        repeat (3) @(negedge clk);
        report();
        $finish;
    end
endmodule